// File: doc/BRIEF.md
# Integer Data-Processing ALU with Per-Opcode Flag Classes

This block is the combinational arithmetic and logic stage of a classic 32-bit data-processing datapath. It receives a 4-bit operation code, a first operand taken straight from the register file, and a second operand that an upstream barrel shifter or immediate rotator has already prepared. It also receives the carry bit that unit produced and the current condition flags. It returns the 32-bit result, a strobe saying whether the destination register is written, and the condition flags for the next instruction.

Each operation code belongs to one of four flag classes, and the class decides how carry and overflow are formed. Additions report the plain carry-out and signed overflow. Subtractions are built as an addition of the inverted second operand, so carry means "no borrow". Reverse subtractions invert the first operand instead. Logical operations take carry from the shifter and keep overflow unchanged. Negative and zero always follow the result. The flags change only when the set-flags input is high. A single shared adder serves every arithmetic class.

Top module: `dp_alu`

## Requirements
- R1: Opcode 0x4 gives op_a + op_b, 0x2 gives op_a - op_b, and 0x3 gives op_b - op_a (reverse order), all modulo 2^32.
- R2: Opcode 0x5 gives op_a + op_b + C, 0x6 gives op_a - op_b - (1 - C), and 0x7 gives op_b - op_a - (1 - C), where C is flags_in[1].
- R3: Logical opcodes compute 0x0 AND, 0x1 XOR, 0xC OR, 0xD pass op_b, 0xE op_a AND NOT op_b, and 0xF NOT op_b. Opcodes 0x8 and 0x9 compute AND and XOR.
- R4: rd_write is low for opcodes 0x8, 0x9, 0xA and 0xB, and high for every other opcode. These four opcodes still drive result: 0xA as op_a - op_b and 0xB as op_a + op_b.
- R5: With set_flags high, flags_out[3] (N) equals result bit 31 and flags_out[2] (Z) is 1 exactly when result is zero.
- R6: For the add class (0x4, 0x5, 0xB), flags_out[1] is the unsigned carry-out and flags_out[0] is the signed overflow of the addition, including any carry-in.
- R7: For the subtract class (0x2, 0x6, 0xA), C and V are the carry and signed overflow of op_a + NOT op_b + carry-in. C is 1 when no borrow occurs.
- R8: For the reverse-subtract class (0x3, 0x7), C and V are the carry and signed overflow of op_b + NOT op_a + carry-in.
- R9: For logical opcodes with imm_op low, C takes shift_carry and V keeps flags_in[0].
- R10: For logical opcodes with imm_op high, C takes shift_carry when imm_rot_nz is high and keeps flags_in[1] when imm_rot_nz is low.
- R11: With set_flags low, flags_out equals flags_in for every opcode. The flag vector is ordered {N, Z, C, V}, from bit 3 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 4 | Operation selector |
| op_a | input | 32 | First operand from the register file |
| op_b | input | 32 | Second operand from the shifter or immediate rotator |
| shift_carry | input | 1 | Carry bit produced by the shifter or rotator |
| imm_op | input | 1 | High when op_b is a rotated immediate |
| imm_rot_nz | input | 1 | High when the immediate rotate amount is nonzero |
| set_flags | input | 1 | Allows the flags to update |
| flags_in | input | 4 | Current flags {N, Z, C, V} |
| result | output | 32 | Operation result |
| rd_write | output | 1 | Destination write enable |
| flags_out | output | 4 | Next flags {N, Z, C, V} |

## Verification
The carry-in path and the flag-class selector act in the same evaluation when a carry-consuming opcode runs with set_flags high. In that case the incoming C changes both the result and the new C. The bench provokes this with edge cases for add-with-carry, subtract-with-carry and reverse-subtract-with-carry: a sum that wraps exactly to zero, and equal operands with C clear, which gives all ones and a borrow. It then compares result, Z, N, C and V against a model that works in wide signed and unsigned integers rather than bit logic. The same vectors are rerun with set_flags low to confirm that the result still changes while the flags hold.

// File: rtl/dp_alu_pkg.sv
// Package: shared opcode, flag-class and control types for the data-processing ALU.
// Assumes a 4-bit opcode and a flag vector ordered {N,Z,C,V}.
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'd0,
        CLS_SUB   = 2'd1,
        CLS_RSB   = 2'd2,
        CLS_LOGIC = 2'd3
    } flag_class_e;

    typedef enum logic [2:0] {
        LF_AND = 3'd0,
        LF_EOR = 3'd1,
        LF_ORR = 3'd2,
        LF_MOV = 3'd3,
        LF_BIC = 3'd4,
        LF_MVN = 3'd5
    } logic_fn_e;

    typedef struct packed {
        flag_class_e cls;
        logic_fn_e   lfn;
        logic        use_cin;
        logic        writes_rd;
    } alu_ctrl_t;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;
    localparam int NFLAGS = 4;

endpackage

// File: rtl/dp_alu_decode.sv
// Module: dp_alu_decode
// Turns the 4-bit opcode into the flag class, logic function, carry-in use
// and destination write strobe. Purely combinational; every code is defined.
module dp_alu_decode
    import dp_alu_pkg::*;
(
    input  logic [3:0] opcode,
    output alu_ctrl_t  ctrl
);

    // Map each opcode to its control bundle.
    always_comb begin
        ctrl = '{cls: CLS_LOGIC, lfn: LF_AND, use_cin: 1'b0, writes_rd: 1'b1};
        unique case (opcode_e'(opcode))
            OP_AND: ctrl.lfn = LF_AND;
            OP_EOR: ctrl.lfn = LF_EOR;
            OP_SUB: ctrl.cls = CLS_SUB;
            OP_RSB: ctrl.cls = CLS_RSB;
            OP_ADD: ctrl.cls = CLS_ADD;
            OP_ADC: begin ctrl.cls = CLS_ADD; ctrl.use_cin = 1'b1; end
            OP_SBC: begin ctrl.cls = CLS_SUB; ctrl.use_cin = 1'b1; end
            OP_RSC: begin ctrl.cls = CLS_RSB; ctrl.use_cin = 1'b1; end
            OP_TST: begin ctrl.lfn = LF_AND; ctrl.writes_rd = 1'b0; end
            OP_TEQ: begin ctrl.lfn = LF_EOR; ctrl.writes_rd = 1'b0; end
            OP_CMP: begin ctrl.cls = CLS_SUB; ctrl.writes_rd = 1'b0; end
            OP_CMN: begin ctrl.cls = CLS_ADD; ctrl.writes_rd = 1'b0; end
            OP_ORR: ctrl.lfn = LF_ORR;
            OP_MOV: ctrl.lfn = LF_MOV;
            OP_BIC: ctrl.lfn = LF_BIC;
            OP_MVN: ctrl.lfn = LF_MVN;
            default: ctrl.lfn = LF_AND;
        endcase
    end

endmodule

// File: rtl/dp_alu_arith.sv
// Module: dp_alu_arith
// One shared adder for the add, subtract and reverse-subtract classes.
// Subtraction is formed as x + ~y + cin. The carry-in is the stored C when
// use_cin is set, otherwise 0 for add and 1 for the subtract forms.
// RIPPLE=1 builds an explicit bit chain; RIPPLE=0 leaves the adder to synthesis.
module dp_alu_arith
    import dp_alu_pkg::*;
#(
    parameter int W      = 32,
    parameter bit RIPPLE = 1'b0
) (
    input  flag_class_e  cls,
    input  logic         use_cin,
    input  logic         c_in,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf
);

    localparam int MSB = W - 1;

    logic [W-1:0] x;
    logic [W-1:0] y;
    logic         cin;

    // Route and invert operands according to the flag class.
    always_comb begin
        unique case (cls)
            CLS_SUB: begin x = op_a; y = ~op_b; cin = use_cin ? c_in : 1'b1; end
            CLS_RSB: begin x = op_b; y = ~op_a; cin = use_cin ? c_in : 1'b1; end
            default: begin x = op_a; y = op_b;  cin = use_cin ? c_in : 1'b0; end
        endcase
    end

    generate
        if (RIPPLE) begin : g_ripple
            logic [W:0] cy;
            assign cy[0] = cin;
            for (genvar i = 0; i < W; i++) begin : g_bit
                assign sum[i]   = x[i] ^ y[i] ^ cy[i];
                assign cy[i+1]  = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
            end
            assign carry = cy[W];
        end else begin : g_behav
            logic [W:0] wide;
            assign wide  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
            assign sum   = wide[MSB:0];
            assign carry = wide[W];
        end
    endgenerate

    // Signed overflow: operands agree in sign, the sum disagrees.
    assign ovf = ~(x[MSB] ^ y[MSB]) & (sum[MSB] ^ x[MSB]);

endmodule

// File: rtl/dp_alu_logic.sv
// Module: dp_alu_logic
// Bitwise unit for the logical opcodes. Produces no flags itself.
module dp_alu_logic
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic_fn_e    lfn,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] res
);

    // Select the bitwise function.
    always_comb begin
        unique case (lfn)
            LF_AND:  res = op_a & op_b;
            LF_EOR:  res = op_a ^ op_b;
            LF_ORR:  res = op_a | op_b;
            LF_MOV:  res = op_b;
            LF_BIC:  res = op_a & ~op_b;
            LF_MVN:  res = ~op_b;
            default: res = op_a & op_b;
        endcase
    end

endmodule

// File: rtl/dp_alu_flags.sv
// Module: dp_alu_flags
// Forms the next {N,Z,C,V}. N and Z come from the result. C and V come from
// the adder for arithmetic classes. Logical ops take C from the shifter, or hold
// it for an immediate with zero rotation, and keep V unchanged.
module dp_alu_flags
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  flag_class_e        cls,
    input  logic               set_flags,
    input  logic [NFLAGS-1:0]  flags_in,
    input  logic [W-1:0]       result,
    input  logic               arith_c,
    input  logic               arith_v,
    input  logic               shift_carry,
    input  logic               imm_op,
    input  logic               imm_rot_nz,
    output logic [NFLAGS-1:0]  flags_out
);

    localparam int MSB = W - 1;

    logic nxt_c;
    logic nxt_v;
    logic logic_c;

    // Carry source for the logical class.
    always_comb begin
        if (imm_op && !imm_rot_nz) logic_c = flags_in[FLAG_C];
        else                       logic_c = shift_carry;
    end

    // Pick C and V by flag class.
    always_comb begin
        if (cls == CLS_LOGIC) begin
            nxt_c = logic_c;
            nxt_v = flags_in[FLAG_V];
        end else begin
            nxt_c = arith_c;
            nxt_v = arith_v;
        end
    end

    // Assemble the flag vector, gated by set_flags.
    always_comb begin
        if (set_flags) begin
            flags_out[FLAG_N] = result[MSB];
            flags_out[FLAG_Z] = ~|result;
            flags_out[FLAG_C] = nxt_c;
            flags_out[FLAG_V] = nxt_v;
        end else begin
            flags_out = flags_in;
        end
    end

endmodule

// File: rtl/dp_alu.sv
// Module: dp_alu (top)
// Combinational data-processing ALU. It assumes op_b is already shifted or
// rotated upstream and that shift_carry is that unit's carry output. Holds no
// state, so it has no clock or reset.
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int W      = 32,
    parameter bit RIPPLE = 1'b0
) (
    input  logic [3:0]        opcode,
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic              shift_carry,
    input  logic              imm_op,
    input  logic              imm_rot_nz,
    input  logic              set_flags,
    input  logic [NFLAGS-1:0] flags_in,
    output logic [W-1:0]      result,
    output logic              rd_write,
    output logic [NFLAGS-1:0] flags_out
);

    alu_ctrl_t    ctrl;
    logic [W-1:0] arith_sum;
    logic [W-1:0] logic_res;
    logic         arith_c;
    logic         arith_v;

    dp_alu_decode u_dec (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    dp_alu_arith #(.W(W), .RIPPLE(RIPPLE)) u_arith (
        .cls     (ctrl.cls),
        .use_cin (ctrl.use_cin),
        .c_in    (flags_in[FLAG_C]),
        .op_a    (op_a),
        .op_b    (op_b),
        .sum     (arith_sum),
        .carry   (arith_c),
        .ovf     (arith_v)
    );

    dp_alu_logic #(.W(W)) u_logic (
        .lfn  (ctrl.lfn),
        .op_a (op_a),
        .op_b (op_b),
        .res  (logic_res)
    );

    // Choose the result source by class.
    always_comb begin
        result = (ctrl.cls == CLS_LOGIC) ? logic_res : arith_sum;
    end

    assign rd_write = ctrl.writes_rd;

    dp_alu_flags #(.W(W)) u_flags (
        .cls         (ctrl.cls),
        .set_flags   (set_flags),
        .flags_in    (flags_in),
        .result      (result),
        .arith_c     (arith_c),
        .arith_v     (arith_v),
        .shift_carry (shift_carry),
        .imm_op      (imm_op),
        .imm_rot_nz  (imm_rot_nz),
        .flags_out   (flags_out)
    );

endmodule

// File: rtl/dp_alu_checker.sv
// Module: dp_alu_checker
// Assertions on the ALU ports. They are immediate because the block holds no
// state, and each is guarded against unknown inputs before stimulus starts.
module dp_alu_checker
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input logic [3:0]        opcode,
    input logic [W-1:0]      op_a,
    input logic [W-1:0]      op_b,
    input logic              shift_carry,
    input logic              imm_op,
    input logic              imm_rot_nz,
    input logic              set_flags,
    input logic [NFLAGS-1:0] flags_in,
    input logic [W-1:0]      result,
    input logic              rd_write,
    input logic [NFLAGS-1:0] flags_out
);

    logic known;
    logic is_logic;

    // Inputs are fully driven.
    always_comb known = !$isunknown({opcode, op_a, op_b, shift_carry, imm_op,
                                     imm_rot_nz, set_flags, flags_in});

    // Opcodes of the logical class.
    always_comb is_logic = (opcode <= 4'h1) || (opcode == 4'h8) ||
                           (opcode == 4'h9) || (opcode >= 4'hC);

    // Assertion checks across the port relations.
    always_comb begin
        if (known) begin
            assert_flags_hold_R11: assert (set_flags || flags_out == flags_in)
                else $error("flags changed with set_flags low");
            assert_n_flag_R5: assert (!set_flags || flags_out[FLAG_N] == result[W-1])
                else $error("N does not follow result sign");
            assert_z_flag_R5: assert (!set_flags || flags_out[FLAG_Z] == (result == '0))
                else $error("Z does not follow zero result");
            assert_no_write_R4: assert (rd_write == (opcode[3:2] != 2'b10))
                else $error("destination write strobe wrong");
            assert_mov_pass_R3: assert (opcode != 4'hD || result == op_b)
                else $error("move does not pass op_b");
            assert_sub_noborrow_R7: assert (!(set_flags && (opcode == 4'h2 || opcode == 4'hA))
                                            || flags_out[FLAG_C] == (op_a >= op_b))
                else $error("subtract carry is not no-borrow");
            assert_logic_v_R9: assert (!(set_flags && is_logic)
                                       || flags_out[FLAG_V] == flags_in[FLAG_V])
                else $error("logical op altered V");
            assert_reg_carry_R9: assert (!(set_flags && is_logic && !imm_op)
                                         || flags_out[FLAG_C] == shift_carry)
                else $error("logical op carry not from shifter");
            assert_imm_carry_R10: assert (!(set_flags && is_logic && imm_op)
                                          || flags_out[FLAG_C] ==
                                             (imm_rot_nz ? shift_carry : flags_in[FLAG_C]))
                else $error("immediate logical carry wrong");
        end
    end

endmodule

bind dp_alu dp_alu_checker #(.W(W)) u_chk (
    .opcode      (opcode),
    .op_a        (op_a),
    .op_b        (op_b),
    .shift_carry (shift_carry),
    .imm_op      (imm_op),
    .imm_rot_nz  (imm_rot_nz),
    .set_flags   (set_flags),
    .flags_in    (flags_in),
    .result      (result),
    .rd_write    (rd_write),
    .flags_out   (flags_out)
);

// File: tb/dp_alu_test.sv
`timescale 1ns/1ps
// Directed bench for dp_alu: one task per scenario, each checking its own results.
module dp_alu_test;

    logic        clk = 1'b0;
    logic [3:0]  opcode;
    logic [31:0] op_a, op_b;
    logic        shift_carry, imm_op, imm_rot_nz, set_flags;
    logic [3:0]  flags_in;
    logic [31:0] result;
    logic        rd_write;
    logic [3:0]  flags_out;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dp_alu uut (
        .opcode(opcode), .op_a(op_a), .op_b(op_b), .shift_carry(shift_carry),
        .imm_op(imm_op), .imm_rot_nz(imm_rot_nz), .set_flags(set_flags),
        .flags_in(flags_in), .result(result), .rd_write(rd_write),
        .flags_out(flags_out)
    );

    // Reference built from the requirements with wide integer arithmetic.
    function automatic logic [36:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [3:0] fl,
                                          input logic sf, input logic shc,
                                          input logic imm, input logic rnz);
        logic [31:0] r, x, y;
        logic        c, v, wr, ar, ci;
        longint      us, ss;
        ar = 1'b1; x = a; y = b; ci = 1'b0;
        case (op)
            4'h4, 4'hB: begin x = a;  y = b;  ci = 1'b0;  end
            4'h5:       begin x = a;  y = b;  ci = fl[1]; end
            4'h2, 4'hA: begin x = a;  y = ~b; ci = 1'b1;  end
            4'h6:       begin x = a;  y = ~b; ci = fl[1]; end
            4'h3:       begin x = b;  y = ~a; ci = 1'b1;  end
            4'h7:       begin x = b;  y = ~a; ci = fl[1]; end
            default:    ar = 1'b0;
        endcase
        us = longint'({32'd0, x}) + longint'({32'd0, y}) + longint'(ci);
        ss = longint'($signed(x)) + longint'($signed(y)) + longint'(ci);
        if (ar) begin
            r = us[31:0];
            c = (us > 64'sd4294967295);
            v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
        end else begin
            case (op)
                4'h0, 4'h8: r = a & b;
                4'h1, 4'h9: r = a ^ b;
                4'hC:       r = a | b;
                4'hD:       r = b;
                4'hE:       r = a & ~b;
                default:    r = ~b;
            endcase
            c = (imm && !rnz) ? fl[1] : shc;
            v = fl[0];
        end
        wr = !(op >= 4'h8 && op <= 4'hB);
        return {r, wr, (sf ? {r[31], (r == 32'd0), c, v} : fl)};
    endfunction

    // Drive one vector between clock edges and let it settle.
    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [3:0] fl, input logic sf, input logic shc,
                         input logic imm, input logic rnz);
        @(negedge clk);
        opcode = op; op_a = a; op_b = b; flags_in = fl; set_flags = sf;
        shift_carry = shc; imm_op = imm; imm_rot_nz = rnz;
        #1;
    endtask

    // Compare one value and report.
    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Compare every output against the model for the vector now applied.
    task automatic check_model(input string tag);
        logic [36:0] e;
        e = model(opcode, op_a, op_b, flags_in, set_flags, shift_carry, imm_op, imm_rot_nz);
        check({tag, " result"},   result,                 e[36:5]);
        check({tag, " rd_write"}, {31'd0, rd_write},      {31'd0, e[4]});
        check({tag, " flags"},    {28'd0, flags_out},     {28'd0, e[3:0]});
    endtask

    task automatic t_reset_state;
        apply(4'h0, 32'd0, 32'd0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R3 idle result", result, 32'd0);
        check("R4 idle write",  {31'd0, rd_write}, 32'd1);
        check("R11 idle flags", {28'd0, flags_out}, 32'd0);
    endtask

    task automatic t_add_class;
        apply(4'h4, 32'hFFFF_FFFF, 32'd1, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R1 add wrap", result, 32'd0);
        check("R6 add wrap flags", {28'd0, flags_out}, {28'd0, 4'b0110});
        apply(4'h4, 32'h7FFF_FFFF, 32'd1, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R6 add signed ovf", {28'd0, flags_out}, {28'd0, 4'b1001});
        apply(4'hB, 32'h8000_0000, 32'h8000_0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R6 cmn ovf carry", {28'd0, flags_out}, {28'd0, 4'b0111});
        check_model("R4 cmn");
    endtask

    task automatic t_sub_class;
        apply(4'h2, 32'd5, 32'd5, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R7 sub equal flags", {28'd0, flags_out}, {28'd0, 4'b0110});
        apply(4'h2, 32'd3, 32'd5, 4'b0010, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R1 sub negative", result, 32'hFFFF_FFFE);
        check("R7 sub borrow", {28'd0, flags_out}, {28'd0, 4'b1000});
        apply(4'hA, 32'h8000_0000, 32'd1, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R7 cmp ovf", {28'd0, flags_out}, {28'd0, 4'b0011});
        check("R4 cmp result", result, 32'h7FFF_FFFF);
    endtask

    task automatic t_rsb_class;
        apply(4'h3, 32'd5, 32'd3, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R1 rsb result", result, 32'hFFFF_FFFE);
        check("R8 rsb borrow", {28'd0, flags_out}, {28'd0, 4'b1000});
        apply(4'h3, 32'd1, 32'h8000_0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R8 rsb ovf", {28'd0, flags_out}, {28'd0, 4'b0011});
    endtask

    task automatic t_carry_in_ops;
        apply(4'h5, 32'hFFFF_FFFF, 32'd0, 4'b0010, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R2 adc wrap", result, 32'd0);
        check("R6 adc wrap flags", {28'd0, flags_out}, {28'd0, 4'b0110});
        apply(4'h6, 32'd5, 32'd5, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R2 sbc borrow in", result, 32'hFFFF_FFFF);
        check("R7 sbc flags", {28'd0, flags_out}, {28'd0, 4'b1000});
        apply(4'h7, 32'd3, 32'd10, 4'b0010, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R2 rsc no borrow", result, 32'd7);
        check("R8 rsc flags", {28'd0, flags_out}, {28'd0, 4'b0010});
        apply(4'h7, 32'd3, 32'd10, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R2 rsc borrow in", result, 32'd6);
        check("R11 rsc hold", {28'd0, flags_out}, 32'd0);
    endtask

    task automatic t_logic_ops;
        for (int op = 0; op < 16; op++) begin
            if (op <= 1 || op == 8 || op == 9 || op >= 12) begin
                apply(4'(op), 32'hF0F0_1234, 32'h0FF0_00FF, 4'b0001, 1'b1, 1'b1, 1'b0, 1'b0);
                check_model("R3 R9 logic");
            end
        end
        apply(4'hF, 32'd0, 32'hFFFF_FFFF, 4'b1011, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R3 mvn zero", result, 32'd0);
        check("R9 mvn flags", {28'd0, flags_out}, {28'd0, 4'b0101});
    endtask

    task automatic t_compare_writes;
        for (int op = 0; op < 16; op++) begin
            apply(4'(op), 32'd9, 32'd4, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0);
            check("R4 write strobe", {31'd0, rd_write}, {31'd0, !(op >= 8 && op <= 11)});
        end
    endtask

    task automatic t_imm_carry;
        apply(4'hD, 32'd0, 32'h8000_0000, 4'b0010, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R10 rot zero holds C", {28'd0, flags_out}, {28'd0, 4'b1010});
        apply(4'hD, 32'd0, 32'h8000_0000, 4'b0010, 1'b1, 1'b0, 1'b1, 1'b1);
        check("R10 rot nz takes C", {28'd0, flags_out}, {28'd0, 4'b1000});
        apply(4'h0, 32'd1, 32'd1, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R9 reg form C", {28'd0, flags_out}, {28'd0, 4'b0010});
    endtask

    task automatic t_flag_hold_sweep;
        logic [31:0] s;
        s = 32'h1357_9BDF;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
            a = s;
            s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
            b = (i % 7 == 0) ? a : {s[15:0], s[31:16]};
            apply(4'(i % 16), a, b, s[7:4], s[9], s[10], s[11], s[12]);
            check_model(s[9] ? "R5 R6 R7 R8 sweep" : "R11 sweep");
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        opcode = 4'h0; op_a = '0; op_b = '0; flags_in = '0; set_flags = 1'b0;
        shift_carry = 1'b0; imm_op = 1'b0; imm_rot_nz = 1'b0;
        repeat (2) @(posedge clk);
        t_reset_state();
        t_add_class();
        t_sub_class();
        t_rsb_class();
        t_carry_in_ops();
        t_logic_ops();
        t_compare_writes();
        t_imm_carry();
        t_flag_hold_sweep();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule